// File: doc/BRIEF.md
# Keyed Fractional Bit-Clock Divider

This block makes an audio bit clock from one of up to eight source clocks. Each source is seen as a one-cycle tick strobe in the system clock domain. The output period is an integer count of source ticks. Optionally, a first-order fractional accumulator stretches individual periods by one tick, so that the average ratio comes out as integer plus fraction/4096.

Software programs the block through two 32-bit registers, a control word and a divisor word. A write lands only when its top byte carries the key value 0x5A. Clearing the enable lets the running period finish cleanly, and a busy flag stays high until the clock has actually stopped. A kill bit drops the generator to idle at once.

Top module: `keyed_clkdiv`

## Requirements
- R1: A write (`wr_en` high) changes no register unless `wr_data[31:24]` equals 0x5A. A write with any other top byte leaves the readback and `clk_out` unchanged.
- R2: With `rd_sel`=0 the control word reads back as: source select in bits 3:0, enable in bit 4, kill in bit 5, busy in bit 7, invert in bit 8, shaping mode in bits 10:9. With `rd_sel`=1 it reads the integer divisor in bits 23:12 and the fraction in bits 11:0. Bits 31:24 and all other bits always read zero. `wr_sel` uses the same 0/1 encoding.
- R3: Every output period of P source ticks starts with a rising edge. The output is high for floor(P/2) ticks and low for the remaining ticks.
- R4: In shaping mode 0, P equals the integer divisor and the fraction is ignored.
- R5: In shaping modes 1, 2 and 3 (all treated alike), the fraction is added to a 12-bit accumulator at each period start. A carry past 4095 makes that period one tick longer, and the accumulator keeps the remainder.
- R6: After the enable is cleared, busy stays 1 and the current period runs to the end of its low phase. Then busy falls, with the output low.
- R7: The clock after a write that sets kill, busy and the output are low and the accumulator is cleared. They stay so while kill is 1.
- R8: Select values 1 to 7 run the generator on `src_tick[select]`. Select 0 and 8 to 15 are ground: the generator never starts and busy stays 0.
- R9: The invert bit inverts `clk_out`, including the idle level.
- R10: Integer divisor values 0 and 1 act as 2.
- R11: After reset both registers read zero, busy is 0 and `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write word, key in bits 31:24 |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Readback word, key byte zero |
| src_tick | input | 8 | Per-source tick strobes; bit 0 unused (ground) |
| clk_out | output | 1 | Generated bit clock |

## Verification
The bench builds the block with its default parameters. These give eight sources, a 12-bit integer and fraction, and the fractional path generated in. Both the accumulator carry pattern and the ground selection can therefore be reached. Small divisors (0 to 6) keep periods short, so many periods fit into a short run: stretched periods, clean stop and kill in mid-pulse all occur. One source ticks every third cycle, to show that periods count source ticks and not system cycles.

// File: rtl/keyed_clkdiv_pkg.sv
package keyed_clkdiv_pkg;
   localparam int KEY_LSB  = 24;
   localparam int SEL_W    = 4;
   localparam int B_ENABLE = 4;
   localparam int B_KILL   = 5;
   localparam int B_BUSY   = 7;
   localparam int B_INVERT = 8;
   localparam int B_MODE   = 9;

   typedef struct packed {
      logic [1:0]       mode;
      logic             invert;
      logic             kill;
      logic             enable;
      logic [SEL_W-1:0] src;
   } ctrl_t;
endpackage

// File: rtl/keyed_clkdiv_regs.sv
module keyed_clkdiv_regs
   import keyed_clkdiv_pkg::*;
#(
   parameter int         INT_W  = 12,
   parameter int         FRAC_W = 12,
   parameter logic [7:0] KEY    = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              rd_sel,
   input  logic              busy,
   output logic [31:0]       rd_data,
   output ctrl_t             ctrl,
   output logic [INT_W-1:0]  divi,
   output logic [FRAC_W-1:0] divf
);
   localparam int DIV_W = INT_W + FRAC_W;

   logic key_ok;
   logic unused_bits;

   assign key_ok      = (wr_data[31:KEY_LSB] == KEY);
   assign unused_bits = ^{wr_data[23:11], wr_data[7:6]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         divi <= '0;
         divf <= '0;
      end else if (wr_en && key_ok) begin
         if (!wr_sel) begin
            ctrl.src    <= wr_data[SEL_W-1:0];
            ctrl.enable <= wr_data[B_ENABLE];
            ctrl.kill   <= wr_data[B_KILL];
            ctrl.invert <= wr_data[B_INVERT];
            ctrl.mode   <= wr_data[B_MODE +: 2];
         end else begin
            divi <= wr_data[FRAC_W +: INT_W];
            divf <= wr_data[FRAC_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (!rd_sel) begin
         rd_data[SEL_W-1:0]  = ctrl.src;
         rd_data[B_ENABLE]   = ctrl.enable;
         rd_data[B_KILL]     = ctrl.kill;
         rd_data[B_BUSY]     = busy;
         rd_data[B_INVERT]   = ctrl.invert;
         rd_data[B_MODE +: 2] = ctrl.mode;
      end else begin
         rd_data[DIV_W-1:0] = {divi, divf};
      end
   end

   AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !key_ok) |=> ($stable(ctrl) && $stable(divi) && $stable(divf))); // R1
   AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31:KEY_LSB] == 8'h00); // R2
endmodule

// File: rtl/keyed_clkdiv_frac.sv
module keyed_clkdiv_frac #(
   parameter int INT_W   = 12,
   parameter int FRAC_W  = 12,
   parameter bit MASH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [1:0]        mode,
   input  logic [INT_W-1:0]  divi,
   input  logic [FRAC_W-1:0] divf,
   output logic [INT_W:0]    period
);
   localparam int P_W = INT_W + 1;

   logic [P_W-1:0] base;

   assign base = (divi < INT_W'(2)) ? P_W'(2) : {1'b0, divi};

   generate
      if (MASH_EN) begin : g_frac
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   sum;
         logic              shaped;

         assign shaped = (mode != 2'd0);
         assign sum    = {1'b0, acc} + {1'b0, divf};
         assign period = base + {{INT_W{1'b0}}, shaped & sum[FRAC_W]};

         always_ff @(posedge clk) begin
            if (!rst_n || clear)
               acc <= '0;
            else if (step && shaped)
               acc <= sum[FRAC_W-1:0];
         end

         AST_STRETCH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            step |-> (period == base || period == base + P_W'(1))); // R5
         AST_PLAIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            (step && mode == 2'd0) |-> period == base); // R4
      end else begin : g_int
         logic unused_frac;
         assign unused_frac = ^{clear, step, mode, divf};
         assign period      = base;
      end
   endgenerate
endmodule

// File: rtl/keyed_clkdiv_gen.sv
module keyed_clkdiv_gen #(
   parameter int INT_W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         enable,
   input  logic         kill,
   input  logic [INT_W:0] period,
   output logic         step,
   output logic         running,
   output logic         out_q
);
   localparam int P_W = INT_W + 1;

   logic [P_W-1:0] cnt;
   logic [P_W-1:0] cur_p;
   logic           at_end;
   logic           launch;

   assign at_end = running && tick && (cnt == cur_p - P_W'(1));
   assign launch = !running && tick && enable;
   assign step   = !kill && (launch || (at_end && enable));

   always_ff @(posedge clk) begin
      if (!rst_n || kill) begin
         running <= 1'b0;
         cnt     <= '0;
         cur_p   <= '0;
         out_q   <= 1'b0;
      end else if (step) begin
         running <= 1'b1;
         cnt     <= '0;
         cur_p   <= period;
         out_q   <= 1'b1;
      end else if (at_end) begin
         running <= 1'b0;
         cnt     <= '0;
         out_q   <= 1'b0;
      end else if (running && tick) begin
         cnt   <= cnt + P_W'(1);
         out_q <= (cnt + P_W'(1)) < (cur_p >> 1);
      end
   end

   AST_CLEAN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(running) && !$past(kill)) |-> !$past(out_q)); // R6
   AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!running && !out_q)); // R7
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !out_q); // R3
   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> out_q); // R3
endmodule

// File: rtl/keyed_clkdiv.sv
module keyed_clkdiv
   import keyed_clkdiv_pkg::*;
#(
   parameter int         NSRC    = 8,
   parameter int         INT_W   = 12,
   parameter int         FRAC_W  = 12,
   parameter logic [7:0] KEY     = 8'h5A,
   parameter bit         MASH_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [31:0]     wr_data,
   input  logic            rd_sel,
   output logic [31:0]     rd_data,
   input  logic [NSRC-1:0] src_tick,
   output logic            clk_out
);
   localparam int P_W = INT_W + 1;

   generate
      if (INT_W + FRAC_W > KEY_LSB) begin : g_bad_width
         $error("divisor fields overlap the key byte");
      end
      if (NSRC < 2 || NSRC > (1 << SEL_W)) begin : g_bad_nsrc
         $error("source count out of range");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [INT_W-1:0]  divi;
   logic [FRAC_W-1:0] divf;
   logic [P_W-1:0]    period;
   logic              tick;
   logic              step;
   logic              running;
   logic              out_q;
   logic              unused_ground;

   assign unused_ground = src_tick[0];

   always_comb begin
      tick = 1'b0;
      for (int i = 1; i < NSRC; i++)
         if (ctrl.src == SEL_W'(i)) tick = src_tick[i];
   end

   keyed_clkdiv_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .KEY(KEY)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .busy(running),
      .rd_data(rd_data), .ctrl(ctrl), .divi(divi), .divf(divf)
   );

   keyed_clkdiv_frac #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MASH_EN(MASH_EN)) i_frac (
      .clk(clk), .rst_n(rst_n), .clear(ctrl.kill), .step(step),
      .mode(ctrl.mode), .divi(divi), .divf(divf), .period(period)
   );

   keyed_clkdiv_gen #(.INT_W(INT_W)) i_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl.enable),
      .kill(ctrl.kill), .period(period), .step(step),
      .running(running), .out_q(out_q)
   );

   assign clk_out = out_q ^ ctrl.invert;

   AST_GROUND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.src == '0 && !running) |=> !running); // R8
   AST_INVERT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (clk_out == ctrl.invert)); // R9
endmodule

// File: tb/test_keyed_clkdiv.sv
module test_keyed_clkdiv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [7:0]  src_tick = '0;
   logic        clk_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int phase = 0;

   always #4 clk = ~clk;

   keyed_clkdiv i_keyed_clkdiv (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .src_tick(src_tick), .clk_out(clk_out)
   );

   // source ticks: 1 every cycle, 4 every third cycle, ground bit toggling
   always @(negedge clk) begin
      phase <= phase + 1;
      src_tick <= {1'b0, 1'b0, (phase % 2 == 0), (phase % 3 == 0), 1'b1, 1'b0, 1'b1, ~src_tick[0]};
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference, updated on each edge and compared 1 ns later
   int m_src, m_en, m_kill, m_inv, m_mode, m_divi, m_divf;
   int m_run, m_cnt, m_p, m_out, m_acc;
   always @(posedge clk) begin
      int tk, s, nb;
      cyc++;
      if (!rst_n) begin
         {m_src, m_en, m_kill, m_inv, m_mode, m_divi, m_divf} = '{default:0};
         {m_run, m_cnt, m_p, m_out, m_acc} = '{default:0};
      end else begin
         tk = (m_src >= 1 && m_src <= 7) ? int'(src_tick[m_src]) : 0;
         if (m_kill != 0) begin
            m_run = 0; m_cnt = 0; m_out = 0; m_acc = 0;
         end else begin
            nb = (m_run != 0 && tk != 0 && m_cnt == m_p - 1) ? 1 : 0;
            if (m_en != 0 && ((m_run == 0 && tk != 0) || nb != 0)) begin
               m_p = (m_divi < 2) ? 2 : m_divi;
               if (m_mode != 0) begin
                  s = m_acc + m_divf;
                  if (s >= 4096) begin s -= 4096; m_p++; end
                  m_acc = s;
               end
               m_run = 1; m_cnt = 0; m_out = 1;
            end else if (nb != 0) begin
               m_run = 0; m_cnt = 0; m_out = 0;
            end else if (m_run != 0 && tk != 0) begin
               m_cnt++;
               m_out = (m_cnt < m_p / 2) ? 1 : 0;
            end
         end
         if (wr_en && wr_data[31:24] == 8'h5A) begin
            if (!wr_sel) begin
               m_src = int'(wr_data[3:0]); m_en = int'(wr_data[4]); m_kill = int'(wr_data[5]);
               m_inv = int'(wr_data[8]); m_mode = int'(wr_data[10:9]);
            end else begin
               m_divi = int'(wr_data[23:12]); m_divf = int'(wr_data[11:0]);
            end
         end
      end
      #1;
      check("R3 cycle model clk_out", {31'b0, clk_out}, {31'b0, 1'(m_out ^ m_inv)});
      if (!rd_sel)
         check("R2 cycle model control", rd_data,
               {21'b0, 2'(m_mode), 1'(m_inv), 1'(m_run), 1'b0, 1'(m_kill), 1'(m_en), 4'(m_src)});
      else
         check("R2 cycle model divisor", rd_data, {8'h00, 12'(m_divi), 12'(m_divf)});
   end

   function automatic logic [31:0] ctl(input int src, en, kl, inv, mode, input logic [7:0] key = 8'h5A);
      return {key, 13'b0, 2'(mode), 1'(inv), 2'b0, 1'(kl), 1'(en), 4'(src)};
   endfunction

   function automatic logic [31:0] dvw(input int di, df);
      return {8'h5A, 12'(di), 12'(df)};
   endfunction

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic next_rise(output int t);
      logic prev;
      prev = clk_out;
      t = -1;
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (!prev && clk_out) begin t = cyc; break; end
         prev = clk_out;
      end
   endtask

   task automatic idle_reset;
      wr(1'b0, ctl(1, 0, 1, 0, 0));
      wr(1'b0, ctl(1, 0, 0, 0, 0));
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int t0, t1, sum, w;
      repeat (3) @(negedge clk);
      rd_sel = 1'b0;
      check("R11 reset control", rd_data, 32'h0);
      check("R11 reset clk_out", {31'b0, clk_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: wrong key ignored
      wr(1'b0, ctl(1, 1, 0, 1, 1, 8'hA5));
      repeat (5) @(negedge clk);
      check("R1 bad key control", rd_data, 32'h0);
      check("R1 bad key clk_out", {31'b0, clk_out}, 32'h0);

      // R2: divisor readback with key byte zero
      wr(1'b1, dvw(12'hABC, 12'h123));
      rd_sel = 1'b1; @(negedge clk);
      check("R2 divisor readback", rd_data, 32'h00ABC123);
      wr(1'b1, {8'h33, 24'h0});
      check("R1 bad key divisor", rd_data, 32'h00ABC123);
      rd_sel = 1'b0;

      // R4 and R3: mode 0 ignores the fraction; high width floor(P/2)
      wr(1'b1, dvw(4, 2048));
      wr(1'b0, ctl(1, 1, 0, 0, 0));
      next_rise(t0);
      for (int k = 0; k < 4; k++) begin
         next_rise(t1);
         check("R4 integer period", t1 - t0, 4);
         t0 = t1;
      end
      wr(1'b1, dvw(5, 0));
      next_rise(t0); next_rise(t0);
      w = 0;
      while (clk_out && w < 20) begin @(negedge clk); w++; end
      check("R3 high width P=5", w, 2);

      // R6: clean stop
      next_rise(t0);
      wr(1'b0, ctl(1, 0, 0, 0, 0));
      check("R6 busy held after disable", {31'b0, rd_data[7]}, 32'h1);
      w = 0;
      while (rd_data[7] && w < 40) begin @(negedge clk); w++; end
      check("R6 stop at period end", cyc - t0, 5);
      check("R6 output low at stop", {31'b0, clk_out}, 32'h0);

      // R5: fraction 1024, accumulator from zero: 3,3,3,4
      idle_reset();
      wr(1'b1, dvw(3, 1024));
      wr(1'b0, ctl(1, 1, 0, 0, 1));
      next_rise(t0);
      for (int k = 0; k < 4; k++) begin
         next_rise(t1);
         check("R5 stretched sequence", t1 - t0, (k == 3) ? 4 : 3);
         t0 = t1;
      end

      // R7: kill mid-pulse
      while (!clk_out) @(negedge clk);
      wr(1'b0, ctl(1, 1, 1, 0, 1));
      @(negedge clk);
      check("R7 kill output", {31'b0, clk_out}, 32'h0);
      check("R7 kill busy", {31'b0, rd_data[7]}, 32'h0);
      repeat (6) @(negedge clk);
      check("R7 held while kill", {31'b0, clk_out | rd_data[7]}, 32'h0);

      // R5: mode 2 acts as mode 1, fraction 0.5 -> 28 over 8
      wr(1'b1, dvw(3, 2048));
      wr(1'b0, ctl(1, 1, 0, 0, 2));
      next_rise(t0); sum = 0;
      for (int k = 0; k < 8; k++) begin next_rise(t1); sum += t1 - t0; t0 = t1; end
      check("R5 mode 2 average", sum, 28);

      // R10: divisor 0 acts as 2
      idle_reset();
      wr(1'b1, dvw(0, 0));
      wr(1'b0, ctl(1, 1, 0, 0, 0));
      next_rise(t0); next_rise(t1);
      check("R10 divisor zero", t1 - t0, 2);

      // R8: slower source, then ground and out-of-range select
      wr(1'b0, ctl(4, 1, 0, 0, 0));
      next_rise(t0); next_rise(t0); next_rise(t1);
      check("R8 source four period", t1 - t0, 6);
      idle_reset();
      wr(1'b0, ctl(0, 1, 0, 0, 0));
      w = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); w += int'(clk_out) + int'(rd_data[7]); end
      check("R8 ground never starts", w, 0);
      wr(1'b0, ctl(9, 1, 0, 0, 0));
      w = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); w += int'(clk_out) + int'(rd_data[7]); end
      check("R8 select above range", w, 0);

      // R9: invert at idle
      wr(1'b0, ctl(0, 0, 0, 1, 0));
      check("R9 inverted idle", {31'b0, clk_out}, 32'h1);

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule